// File: doc/BRIEF.md
# Card Host Interrupt Flag Register

This block holds the eight interrupt flags of a memory-card host controller. The flags latch events from the FIFO and transfer logic. Two FIFO flags are set on the edge where the FIFO turns empty while sending, or turns full while receiving. The other six flags are set by single-cycle event pulses. Every set is gated by a per-flag enable input. The flags are gathered into three level-sensitive interrupt request lines.

Software sees the flags as one 8-bit register with a read strobe and a write strobe. No address is needed. To clear a flag, software must first read it as 1, and then write 0 to it. Each read records, bit by bit, which flags were 1 at that moment; these bits are the arm bits. A later write of 0 clears only the armed flags, and those flags lose their arm. Writing 1 never sets a flag. A flag written 1 keeps its arm. A set event always beats a clear in the same cycle, so no event is lost.

Flag positions: bit 7 FIFO empty, bit 6 FIFO full, bit 5 response received, bit 4 data transfer done, bit 3 command sent, bit 2 busy released, bit 1 response timeout, bit 0 busy timeout.

Top module: `card_irq_flags`

## Requirements
- R1: After reset all eight flags read 0 and all three interrupt lines are 0.
- R2: Flag bit 7 sets when `fifo_empty` goes from 0 to 1 while `tx_active` and `flag_en[7]` are both 1. It does not set without that rising edge, while sending is idle, or while its enable is 0.
- R3: Flag bit 6 sets when `fifo_full` goes from 0 to 1 while `rx_active` and `flag_en[6]` are both 1. It does not set under any other condition.
- R4: Flag bit i (0 to 5) sets one cycle after a pulse on `evt[i]` while `flag_en[i]` is 1. A pulse while `flag_en[i]` is 0 leaves the flag unchanged.
- R5: A write with `wr_data` bit i = 0 clears flag i when flag i read as 1 in the most recent read.
- R6: A write of 0 has no effect on a flag that was 0 at the most recent read, including a flag that set after that read.
- R7: Writing 1 to a flag bit neither sets nor clears it. A flag written 1 stays armed.
- R8: A flag cleared by a write loses its arm. If it is set again, a further write of 0 with no read in between leaves it set.
- R9: When a set event and a clearing write reach the same flag in the same cycle, the flag is 1 afterwards.
- R10: `irq[0]` is the OR of flags 7 and 6, `irq[1]` is the OR of flags 5 to 2, and `irq[2]` is the OR of flags 1 and 0. Each line stays at 1 until all of its flags are cleared.
- R11: `rd_data` always shows the current flag values. A read returns the flags as they were before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Register read strobe; arms the flags that read as 1 |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; 0 bits clear armed flags |
| rd_data | output | 8 | Current flag values |
| flag_en | input | 8 | Per-flag set enable, same bit positions as the flags |
| fifo_empty | input | 1 | FIFO empty status level |
| fifo_full | input | 1 | FIFO full status level |
| tx_active | input | 1 | Data is being sent to the card |
| rx_active | input | 1 | Data is being received from the card |
| evt | input | 6 | Set pulses for flags 5 to 0 |
| irq | output | 3 | Grouped interrupt request lines |

## Verification
The hardest cases to reach are the ones that depend on the arm history rather than on the flag values. These are: a flag that sets after the read that would have armed it, a flag that was cleared and then set again, and a set pulse that lands in the very cycle of the clearing write. The bench reaches them with sequences of reads, event pulses and writes, placed at exact cycles. Each scenario starts from a known state: a read of all flags followed by a write of all zeros.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned PULSE_W  = 6;
  localparam int unsigned IRQ_W    = 3;
  localparam int unsigned BIT_FEMPTY = 7;
  localparam int unsigned BIT_FFULL  = 6;
  // group masks, line 0 in the low byte
  localparam logic [IRQ_W*FLAG_W-1:0] IRQ_MAP_DEF =
    {8'b0000_0011, 8'b0011_1100, 8'b1100_0000};
endpackage

// File: rtl/card_irq_setgen.sv
module card_irq_setgen
  import card_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLAG_W-1:0]  en_i,
  input  logic               fifo_empty_i,
  input  logic               fifo_full_i,
  input  logic               tx_active_i,
  input  logic               rx_active_i,
  input  logic [PULSE_W-1:0] evt_i,
  output logic [FLAG_W-1:0]  set_o
);
  logic empty_q, empty_d, full_q, full_d;

  always_comb begin
    empty_d = fifo_empty_i;
    full_d  = fifo_full_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  always_comb begin
    set_o = '0;
    set_o[BIT_FEMPTY] = fifo_empty_i & ~empty_q & tx_active_i & en_i[BIT_FEMPTY];
    set_o[BIT_FFULL]  = fifo_full_i  & ~full_q  & rx_active_i & en_i[BIT_FFULL];
    set_o[PULSE_W-1:0] = evt_i & en_i[PULSE_W-1:0];
  end

  AST_EMPTY_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    set_o[BIT_FEMPTY] |-> (tx_active_i && $rose(fifo_empty_i)));  // R2
  AST_FULL_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    set_o[BIT_FFULL] |-> (rx_active_i && $rose(fifo_full_i)));  // R3
endmodule

// File: rtl/card_irq_bank.sv
module card_irq_bank
  import card_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic [FLAG_W-1:0] set_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [FLAG_W-1:0] arm_q, arm_d;
  logic [FLAG_W-1:0] clr;

  always_comb begin
    clr     = {FLAG_W{wr_i}} & ~wdata_i & arm_q;
    flags_d = (flags_q & ~clr) | set_i;
    if (rd_i) arm_d = flags_q & ~clr;
    else      arm_d = arm_q & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      flags_q <= flags_d;
      arm_q   <= arm_d;
    end
  end

  assign flags_o = flags_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));  // R9
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((flags_q & ~$past(flags_q)) == '0));  // R7
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~flags_q &
               ~($past(arm_q) & ~$past(wdata_i) & {FLAG_W{$past(wr_i)}})) == '0));  // R5
  AST_ARM_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|arm_q) |-> $past(rd_i));  // R6
endmodule

// File: rtl/card_irq_group.sv
module card_irq_group
  import card_irq_pkg::*;
#(
  parameter logic [IRQ_W*FLAG_W-1:0] MAP = IRQ_MAP_DEF
) (
  input  logic [FLAG_W-1:0] flags_i,
  output logic [IRQ_W-1:0]  irq_o
);
  for (genvar k = 0; k < IRQ_W; k++) begin : g_line
    assign irq_o[k] = |(flags_i & MAP[k*FLAG_W +: FLAG_W]);
  end
endmodule

// File: rtl/card_irq_flags.sv
module card_irq_flags
  import card_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [FLAG_W-1:0]  wr_data,
  output logic [FLAG_W-1:0]  rd_data,
  input  logic [FLAG_W-1:0]  flag_en,
  input  logic               fifo_empty,
  input  logic               fifo_full,
  input  logic               tx_active,
  input  logic               rx_active,
  input  logic [PULSE_W-1:0] evt,
  output logic [IRQ_W-1:0]   irq
);
  logic [FLAG_W-1:0] set_w, flags_w;

  card_irq_setgen u_setgen (
    .clk(clk), .rst_n(rst_n), .en_i(flag_en),
    .fifo_empty_i(fifo_empty), .fifo_full_i(fifo_full),
    .tx_active_i(tx_active), .rx_active_i(rx_active),
    .evt_i(evt), .set_o(set_w)
  );

  card_irq_bank u_bank (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_stb), .wr_i(wr_stb),
    .wdata_i(wr_data), .set_i(set_w), .flags_o(flags_w)
  );

  card_irq_group #(.MAP(IRQ_MAP_DEF)) u_group (
    .flags_i(flags_w), .irq_o(irq)
  );

  assign rd_data = flags_w;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0) |-> (irq == '0));  // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && irq[0]) |=> irq[0]);  // R10
endmodule

// File: tb/card_irq_flags_tb.sv
module card_irq_flags_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic rd_stb = 0, wr_stb = 0;
  logic [7:0] wr_data = 0, rd_data, flag_en = 0;
  logic fifo_empty = 0, fifo_full = 0, tx_active = 0, rx_active = 0;
  logic [5:0] evt = 0;
  logic [2:0] irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_irq_flags u_dut (.clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .flag_en(flag_en), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .tx_active(tx_active), .rx_active(rx_active), .evt(evt), .irq(irq));

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_op(); rd_stb = 1; step(); rd_stb = 0; endtask
  task automatic wr_op(logic [7:0] d); wr_stb = 1; wr_data = d; step(); wr_stb = 0; endtask
  task automatic pulse(int b); evt[b] = 1; step(); evt[b] = 0; endtask
  task automatic clear_all(); rd_op(); wr_op(8'h00); endtask

  task automatic t_reset();
    chk("R1 flags", rd_data, 8'h00);
    chk("R1 irq", {5'b0, irq}, 8'h00);
  endtask

  task automatic t_fifo_empty();
    flag_en = 8'h80;
    fifo_empty = 1; step(); chk("R2 idle tx", rd_data, 8'h00);
    fifo_empty = 0; step();
    tx_active = 1; fifo_empty = 1; step();
    chk("R2 set", rd_data, 8'h80);
    chk("R10 irq0", {5'b0, irq}, 8'h01);
    step(); step();
    clear_all();
    chk("R2 level no reset", rd_data, 8'h00);
    fifo_empty = 0; step(); flag_en = 8'h00; fifo_empty = 1; step();
    chk("R2 disabled", rd_data, 8'h00);
    fifo_empty = 0; tx_active = 0; step();
  endtask

  task automatic t_fifo_full();
    flag_en = 8'h40;
    fifo_full = 1; step(); chk("R3 idle rx", rd_data, 8'h00);
    fifo_full = 0; rx_active = 1; step();
    fifo_full = 1; step();
    chk("R3 set", rd_data, 8'h40);
    chk("R10 irq0 full", {5'b0, irq}, 8'h01);
    fifo_full = 0; rx_active = 0;
    clear_all(); chk("R3 cleared", rd_data, 8'h00);
  endtask

  task automatic t_pulses();
    logic [7:0] e = 0;
    flag_en = 8'h00;
    for (int b = 0; b < 6; b++) pulse(b);
    chk("R4 disabled", rd_data, 8'h00);
    flag_en = 8'h3F;
    for (int b = 0; b < 6; b++) begin
      pulse(b); e[b] = 1; chk("R4 set", rd_data, e);
    end
    chk("R10 groups", {5'b0, irq}, 8'h06);
  endtask

  task automatic t_clear();
    rd_op(); chk("R11 read", rd_data, 8'h3F);
    wr_op(8'hF0); chk("R5 clear low", rd_data, 8'h30);
    chk("R10 irq2 drop", {5'b0, irq}, 8'h02);
    pulse(3); chk("R4 reset bit3", rd_data, 8'h38);
    wr_op(8'h00); chk("R8 disarmed stays", rd_data, 8'h08);
    chk("R7 armed kept", rd_data & 8'h30, 8'h00);
    clear_all(); chk("R5 full clear", rd_data, 8'h00);
  endtask

  task automatic t_late_set();
    rd_op(); pulse(2); wr_op(8'h00);
    chk("R6 late set kept", rd_data, 8'h04);
    rd_op(); wr_op(8'hFF);
    chk("R7 write ones", rd_data, 8'h04);
    wr_op(8'hFB); chk("R7 arm held", rd_data, 8'h00);
  endtask

  task automatic t_collide();
    pulse(1); rd_op();
    evt[1] = 1; wr_stb = 1; wr_data = 8'h00; step();
    evt[1] = 0; wr_stb = 0;
    chk("R9 set wins", rd_data, 8'h02);
    chk("R10 irq2 hold", {5'b0, irq}, 8'h04);
    clear_all(); chk("R9 then cleared", rd_data, 8'h00);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_fifo_empty();
    t_fifo_full();
    t_pulses();
    t_clear();
    t_late_set();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule